// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator with Register Port

This block makes one pulse-width modulated output under the control of a small 32-bit register port. There are three registers: a control word, a duty (sample) value and a period value. One of two clock-enable strobes is picked as the count source. The strobe passes through a programmable divider and then advances a period counter. Each period opens with the output high. The output stays high while the counter is below the duty value and goes low for the rest of the period.

The duty and period values that software writes land in holding registers. The counter copies them into its working copies only when a new period begins, so a pulse is never cut short by a write. Three status inputs mark low-power and debug states: doze, wait and debug. Each has its own permission flag in the control word. While an input is asserted and its flag is clear, the divider and counter stop where they are and the output keeps its level.

Top module: `pwm_mod_top`

## Requirements
- R1: The control word is at offset 0x00, the duty value at 0x0C and the period value at 0x10. Each reads back the last value written. The control word keeps only bits 0, 15:4, 17:16, 22, 23 and 24, so a write of all ones reads 0x01C3FFF1. The duty and period registers keep their low 16 bits, and the bits above read as zero. Any other offset reads zero.
- R2: While control bit 0 (enable) is clear, the divider and counter are held at zero and the output is low.
- R3: Control bits 15:4 hold the divider value minus one. A value of D makes one counter step for every D+1 accepted source strobes.
- R4: Control bits 17:16 pick the count source. Value 1 selects the bus strobe and value 2 selects the fast strobe. Values 0 and 3 select no strobe, and the output then never changes.
- R5: One output period lasts the working period value plus 2 counter steps.
- R6: Each period the output is high for the first S counter steps, where S is the working duty value. S = 0 keeps the output low, and S at or above the period plus 2 keeps it high.
- R7: New duty and period values take effect only at the start of the next period.
- R8: If doze is asserted while control bit 24 is clear, or wait while bit 23 is clear, or debug while bit 22 is clear, the divider and counter freeze and the output holds its level.
- R9: When the permission flag of an asserted doze, wait or debug input is set, the modulator keeps running.
- R10: After the enable bit is set, the first period starts on the first divided step. The output rises one clock after that step's edge when S > 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Register byte offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| ce_bus | input | 1 | Bus clock-enable strobe (source 1) |
| ce_fast | input | 1 | Fast clock-enable strobe (source 2) |
| doze_in | input | 1 | Doze state indication |
| wait_in | input | 1 | Wait state indication |
| debug_in | input | 1 | Debug halt indication |
| pwm_out | output | 1 | Modulated output |

## Verification
Directed measurements time the gap from one rising edge to the next and the high time. A counter that wraps at the programmed period instead of period plus two, or a divider that is off by one, shows up here as a period one step short or one step long. The duty extremes of zero and above the full period are tested, because a comparison with the wrong sense leaves a one-step glitch pulse. Random writes arrive in the middle of a period while the source strobes and freeze inputs change every cycle. A cycle-by-cycle reference model catches an output that uses a new duty value before the boundary, and it also catches a freeze that is ignored or a freeze applied despite its permission flag.

// File: rtl/pwm_mod_pkg.sv
package pwm_mod_pkg;
   localparam int OFS_CTRL   = 'h00;
   localparam int OFS_SAMPLE = 'h0C;
   localparam int OFS_PERIOD = 'h10;

   localparam int EN_BIT   = 0;
   localparam int PRE_LSB  = 4;
   localparam int PRE_MAXW = 12;
   localparam int SRC_LSB  = 16;
   localparam int DBG_BIT  = 22;
   localparam int WAIT_BIT = 23;
   localparam int DOZE_BIT = 24;

   typedef enum logic [1:0] {
      SRC_OFF  = 2'd0,
      SRC_BUS  = 2'd1,
      SRC_FAST = 2'd2,
      SRC_RSV  = 2'd3
   } src_sel_e;
endpackage

// File: rtl/pwm_mod_regs.sv
module pwm_mod_regs
   import pwm_mod_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int PRE_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] ctrl_o,
   output logic [CNT_W-1:0]  sample_o,
   output logic [CNT_W-1:0]  period_o
);
   localparam logic [DATA_W-1:0] PRE_MASK  = DATA_W'(((64'd1 << PRE_W) - 64'd1) << PRE_LSB);
   localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'((64'd1 << EN_BIT) | (64'd3 << SRC_LSB) |
                                                     (64'd1 << DBG_BIT) | (64'd1 << WAIT_BIT) |
                                                     (64'd1 << DOZE_BIT));
   localparam logic [DATA_W-1:0] CTRL_MASK = PRE_MASK | FLAG_MASK;

   logic sel_ctrl, sel_sample, sel_period;
   logic [DATA_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  sample_q, period_q;

   assign sel_ctrl   = (addr == ADDR_W'(OFS_CTRL));
   assign sel_sample = (addr == ADDR_W'(OFS_SAMPLE));
   assign sel_period = (addr == ADDR_W'(OFS_PERIOD));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         sample_q <= '0;
         period_q <= '0;
      end else if (we) begin
         if (sel_ctrl)   ctrl_q   <= wdata & CTRL_MASK;
         if (sel_sample) sample_q <= wdata[CNT_W-1:0];
         if (sel_period) period_q <= wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (sel_ctrl)        rdata = ctrl_q;
      else if (sel_sample) rdata = DATA_W'(sample_q);
      else if (sel_period) rdata = DATA_W'(period_q);
   end

   assign ctrl_o   = ctrl_q;
   assign sample_o = sample_q;
   assign period_o = period_q;
endmodule

// File: rtl/pwm_mod_prescale.sv
module pwm_mod_prescale #(
   parameter int PRE_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             frz,
   input  logic             src_ce,
   input  logic [PRE_W-1:0] div_m1,
   output logic             tick,
   output logic [PRE_W-1:0] pcnt_q
);
   logic last;

   assign last = (pcnt_q >= div_m1);
   assign tick = en && !frz && src_ce && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pcnt_q <= '0;
      else if (!en)            pcnt_q <= '0;
      else if (!frz && src_ce) pcnt_q <= last ? '0 : pcnt_q + 1'b1;
   end
endmodule

// File: rtl/pwm_mod_core.sv
module pwm_mod_core #(
   parameter int CNT_W   = 16,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic [CNT_W-1:0] sample_in,
   input  logic [CNT_W-1:0] period_in,
   output logic             running,
   output logic [CNT_W:0]   cnt_q,
   output logic [CNT_W-1:0] act_s,
   output logic [CNT_W-1:0] act_p,
   output logic             level,
   output logic             pwm_out
);
   localparam int CW = CNT_W + 1;

   logic [CW-1:0] last_cnt;
   logic          at_end;

   assign last_cnt = CW'(act_p) + CW'(1);
   assign at_end   = (cnt_q >= last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt_q   <= '0;
         act_s   <= '0;
         act_p   <= '0;
      end else if (!en) begin
         running <= 1'b0;
         cnt_q   <= '0;
      end else if (tick) begin
         if (!running || at_end) begin
            running <= 1'b1;
            cnt_q   <= '0;
            act_s   <= sample_in;
            act_p   <= period_in;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign level = running && (cnt_q < CW'(act_s));

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pwm_out <= 1'b0;
            else        pwm_out <= level;
         end
      end else begin : g_out_comb
         assign pwm_out = level;
      end
   endgenerate
endmodule

// File: rtl/pwm_mod_top.sv
module pwm_mod_top
   import pwm_mod_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 16,
   parameter int PRE_W   = 12,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              ce_bus,
   input  logic              ce_fast,
   input  logic              doze_in,
   input  logic              wait_in,
   input  logic              debug_in,
   output logic              pwm_out
);
   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("pwm_mod_top: DATA_W must be 32");
      end
      if (PRE_W < 1 || PRE_W > PRE_MAXW) begin : g_bad_pre
         $error("pwm_mod_top: PRE_W out of range");
      end
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("pwm_mod_top: CNT_W out of range");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("pwm_mod_top: ADDR_W too small for the map");
      end
   endgenerate

   logic [DATA_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  sample_q, period_q;
   logic              ctrl_en, frz, src_ce, tick, running, pwm_level;
   logic [PRE_W-1:0]  pcnt_q;
   logic [CNT_W:0]    cnt_q;
   logic [CNT_W-1:0]  act_s, act_p;
   src_sel_e          src_sel;

   pwm_mod_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
      .rdata(reg_rdata), .ctrl_o(ctrl_q), .sample_o(sample_q), .period_o(period_q)
   );

   assign ctrl_en = ctrl_q[EN_BIT];
   assign src_sel = src_sel_e'(ctrl_q[SRC_LSB +: 2]);
   assign frz     = (doze_in  && !ctrl_q[DOZE_BIT]) ||
                    (wait_in  && !ctrl_q[WAIT_BIT]) ||
                    (debug_in && !ctrl_q[DBG_BIT]);

   always_comb begin
      unique case (src_sel)
         SRC_BUS:  src_ce = ce_bus;
         SRC_FAST: src_ce = ce_fast;
         default:  src_ce = 1'b0;
      endcase
   end

   pwm_mod_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(ctrl_en), .frz(frz), .src_ce(src_ce),
      .div_m1(ctrl_q[PRE_LSB +: PRE_W]), .tick(tick), .pcnt_q(pcnt_q)
   );

   pwm_mod_core #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_core (
      .clk(clk), .rst_n(rst_n), .en(ctrl_en), .tick(tick),
      .sample_in(sample_q), .period_in(period_q), .running(running),
      .cnt_q(cnt_q), .act_s(act_s), .act_p(act_p), .level(pwm_level),
      .pwm_out(pwm_out)
   );
endmodule

// File: rtl/pwm_mod_chk.sv
module pwm_mod_chk #(
   parameter int CNT_W  = 16,
   parameter int PRE_W  = 12,
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctrl_en,
   input logic              frz,
   input logic              tick,
   input logic              running,
   input logic              pwm_level,
   input logic [CNT_W:0]    cnt_q,
   input logic [PRE_W-1:0]  pcnt_q,
   input logic [CNT_W-1:0]  act_s,
   input logic [CNT_W-1:0]  act_p,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_rdata
);
   localparam int CW = CNT_W + 1;

   AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |=> (cnt_q == '0 && pcnt_q == '0 && !running)); // R2
   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !pwm_level); // R2
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt_q <= CW'(act_p) + CW'(1))); // R5
   AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (running && act_s == '0) |-> !pwm_level); // R6
   AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (running && CW'(act_s) >= CW'(act_p) + CW'(2)) |-> pwm_level); // R6
   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !tick) |=> ($stable(act_s) && $stable(act_p))); // R7
   AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en && frz) |=> ($stable(cnt_q) && $stable(pcnt_q) && $stable(pwm_level))); // R8
   AST_FREEZE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      frz |-> !tick); // R8
   AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(0)) |-> ((reg_rdata & ~32'h01C3_FFF1) == '0)); // R1
endmodule

bind pwm_mod_top pwm_mod_chk #(
   .CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .frz(frz), .tick(tick),
   .running(running), .pwm_level(pwm_level), .cnt_q(cnt_q), .pcnt_q(pcnt_q),
   .act_s(act_s), .act_p(act_p), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/pwm_mod_top_bench.sv
module pwm_mod_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ce_bus = 1'b0, ce_fast = 1'b0;
   logic        doze_in = 1'b0, wait_in = 1'b0, debug_in = 1'b0;
   logic        pwm_out;

   int    n_vec = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   string phase = "R2";

   always #2.5 clk = ~clk;

   pwm_mod_top u_pwm_mod_top (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ce_bus(ce_bus),
      .ce_fast(ce_fast), .doze_in(doze_in), .wait_in(wait_in),
      .debug_in(debug_in), .pwm_out(pwm_out)
   );

   // ---------------- reference model built from the requirements
   logic [31:0] m_ctrl;
   int          m_s, m_p, m_pc, m_cnt, m_as, m_ap;
   bit          m_run;

   function automatic logic [31:0] f_ctrl_keep(logic [31:0] d);
      return d & 32'h01C3_FFF1;
   endfunction

   function automatic logic [31:0] f_read(logic [4:0] a);
      case (a)
         5'h00:   return m_ctrl;
         5'h0C:   return 32'(m_s);
         5'h10:   return 32'(m_p);
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit f_expect_out();
      return m_run && (m_cnt < m_as);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl <= '0; m_s <= 0; m_p <= 0; m_pc <= 0; m_cnt <= 0;
         m_as <= 0; m_ap <= 0; m_run <= 1'b0;
      end else begin
         bit frz, ce, stepped;
         int pre;
         frz = (doze_in && !m_ctrl[24]) || (wait_in && !m_ctrl[23]) || (debug_in && !m_ctrl[22]);
         ce  = (m_ctrl[17:16] == 2'd1) ? ce_bus : (m_ctrl[17:16] == 2'd2) ? ce_fast : 1'b0;
         pre = int'(m_ctrl[15:4]);
         if (!m_ctrl[0]) begin
            m_pc <= 0; m_cnt <= 0; m_run <= 1'b0;
         end else if (!frz && ce) begin
            stepped = (m_pc >= pre);
            m_pc <= stepped ? 0 : m_pc + 1;
            if (stepped) begin
               if (!m_run || m_cnt >= m_ap + 1) begin
                  m_run <= 1'b1; m_cnt <= 0; m_as <= m_s; m_ap <= m_p;
               end else begin
                  m_cnt <= m_cnt + 1;
               end
            end
         end
         if (reg_we) begin
            if (reg_addr == 5'h00) m_ctrl <= f_ctrl_keep(reg_wdata);
            if (reg_addr == 5'h0C) m_s <= int'(reg_wdata[15:0]);
            if (reg_addr == 5'h10) m_p <= int'(reg_wdata[15:0]);
         end
      end
   end

   // cycle-by-cycle output comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_vec++;
         if (pwm_out !== f_expect_out()) begin
            n_bad++;
            $display("FAIL %s pwm_out actual=%0b expected=%0b t=%0t", phase, pwm_out, f_expect_out(), $time);
         end
      end
   end

   // ---------------- helpers
   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(string tag, logic [4:0] a, logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic meas(string tag, output int hi, output int per);
      int lo, guard;
      hi = 0; lo = 0; guard = 0;
      @(negedge clk);
      while (pwm_out !== 1'b0 && guard < 400) begin @(negedge clk); guard++; end
      while (pwm_out !== 1'b1 && guard < 400) begin @(negedge clk); guard++; end
      while (pwm_out === 1'b1 && guard < 400) begin hi++; @(negedge clk); guard++; end
      while (pwm_out === 1'b0 && guard < 400) begin lo++; @(negedge clk); guard++; end
      if (guard >= 400) chk({tag, " edge timeout"}, 32'd0, 32'd1);
      per = hi + lo;
   endtask

   task automatic hold_check(string tag, int cycles, logic exp);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         chk(tag, 32'(pwm_out), 32'(exp));
      end
   endtask

   function automatic logic [31:0] f_ctl(bit en, int pre, int src, bit dz, bit wt, bit dbg);
      return 32'(en) | (32'(pre) << 4) | (32'(src) << 16) |
             (32'(dbg) << 22) | (32'(wt) << 23) | (32'(dz) << 24);
   endfunction

   // ---------------- watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R5 watchdog actual=running expected=finished");
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   // ---------------- stimulus
   initial begin
      int hi, per;
      logic held;
      void'($urandom(32'd7331));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      phase = "R2";
      rd("R1 reset ctrl", 5'h00, 32'h0);
      rd("R1 reset sample", 5'h0C, 32'h0);
      rd("R1 reset period", 5'h10, 32'h0);
      chk("R2 reset output", 32'(pwm_out), 32'h0);

      phase = "R1";
      wr(5'h00, 32'hFFFF_FFFE);
      wr(5'h0C, 32'hFFFF_FFFF);
      wr(5'h10, 32'hFFFF_FFFF);
      rd("R1 ctrl readback", 5'h00, 32'h01C3_FFF0);
      rd("R1 sample readback", 5'h0C, 32'h0000_FFFF);
      rd("R1 period readback", 5'h10, 32'h0000_FFFF);
      rd("R1 unmapped 0x04", 5'h04, 32'h0);
      rd("R1 unmapped 0x14", 5'h14, 32'h0);
      wr(5'h00, 32'h0);

      phase = "R10";
      ce_bus = 1'b1;
      wr(5'h0C, 32'd2);
      wr(5'h10, 32'd3);
      wr(5'h00, f_ctl(1, 0, 1, 0, 0, 0));
      chk("R10 low before first step", 32'(pwm_out), 32'h0);
      @(negedge clk);
      chk("R10 high after first step", 32'(pwm_out), 32'h1);

      phase = "R5";
      meas("R5", hi, per);
      chk("R5 period = P+2", 32'(per), 32'd5);
      chk("R6 high time = S", 32'(hi), 32'd2);

      phase = "R3";
      wr(5'h00, f_ctl(1, 2, 1, 0, 0, 0));
      meas("R3", hi, per);
      meas("R3", hi, per);
      chk("R3 divided period", 32'(per), 32'd15);
      chk("R3 divided high", 32'(hi), 32'd6);

      phase = "R4";
      ce_bus = 1'b0; ce_fast = 1'b1;
      wr(5'h00, f_ctl(1, 0, 2, 0, 0, 0));
      meas("R4", hi, per);
      meas("R4", hi, per);
      chk("R4 fast source period", 32'(per), 32'd5);
      wr(5'h00, f_ctl(1, 0, 0, 0, 0, 0));
      ce_bus = 1'b1;
      hold_check("R4 source off stays low", 20, 1'b0);
      wr(5'h00, f_ctl(1, 0, 3, 0, 0, 0));
      hold_check("R4 reserved source stays low", 20, 1'b0);
      ce_fast = 1'b0;

      phase = "R7";
      wr(5'h00, f_ctl(1, 0, 1, 0, 0, 0));
      meas("R7", hi, per);
      wr(5'h10, 32'd9);
      wr(5'h0C, 32'd4);
      meas("R7", hi, per);
      meas("R7", hi, per);
      chk("R7 new period after boundary", 32'(per), 32'd11);
      chk("R7 new duty after boundary", 32'(hi), 32'd4);

      phase = "R6";
      wr(5'h0C, 32'd0);
      repeat (15) @(negedge clk);
      hold_check("R6 zero duty low", 25, 1'b0);
      wr(5'h0C, 32'd11);
      repeat (15) @(negedge clk);
      hold_check("R6 duty at P+2 high", 25, 1'b1);
      wr(5'h0C, 32'd4);
      repeat (15) @(negedge clk);

      phase = "R8";
      @(negedge clk);
      doze_in = 1'b1;
      @(negedge clk);
      held = pwm_out;
      hold_check("R8 doze freeze holds", 30, held);
      doze_in = 1'b0; debug_in = 1'b1;
      @(negedge clk);
      held = pwm_out;
      hold_check("R8 debug freeze holds", 30, held);

      phase = "R9";
      wr(5'h00, f_ctl(1, 0, 1, 0, 0, 1));
      meas("R9", hi, per);
      chk("R9 debug permitted keeps running", 32'(per), 32'd11);
      debug_in = 1'b0;

      phase = "R2";
      wr(5'h0C, 32'd20);
      wr(5'h00, 32'h0);
      hold_check("R2 disabled low", 20, 1'b0);

      phase = "RND R6";
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk);
         ce_bus   = ($urandom % 2) == 0;
         ce_fast  = ($urandom % 2) == 0;
         doze_in  = ($urandom % 100) < 5;
         wait_in  = ($urandom % 100) < 5;
         debug_in = ($urandom % 100) < 5;
         reg_we   = 1'b0;
         if (($urandom % 100) < 4) begin
            int sel;
            sel = $urandom % 3;
            reg_we = 1'b1;
            if (sel == 0) begin
               reg_addr  = 5'h00;
               reg_wdata = f_ctl(($urandom % 10) != 0, $urandom % 4, $urandom % 4,
                                 $urandom % 2, $urandom % 2, $urandom % 2);
            end else if (sel == 1) begin
               reg_addr  = 5'h0C;
               reg_wdata = $urandom % 24;
            end else begin
               reg_addr  = 5'h10;
               reg_wdata = $urandom % 16;
            end
         end else if (($urandom % 100) < 10) begin
            reg_addr = 5'($urandom % 32);
            #1;
            chk("R1 random readback", reg_rdata, f_read(reg_addr));
         end
      end
      @(negedge clk);
      reg_we = 1'b0;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule